// File: doc/BRIEF.md
# Dual-Channel Drive Interrupt Gate

This block sits on the byte-wide host bus of a two-channel disk drive adapter. It gates the raw interrupt line of each drive channel through a per-channel enable latch, ORs the gated lines onto a single host interrupt, and presents a readable status byte per channel. The host arms a channel's enable by writing any value to that channel's enable offset. Reading the same offset disarms it, so reads at that address have a side effect.

The block also decodes the drive register windows of both channels: eight taskfile registers spaced 64 bytes apart, plus one control register. It raises a chip select and register index toward the drive bus, and it returns the drive's read data on the host bus. Four word-spaced locations each return one bit of a 4-bit card type code. A select register at offset zero holds the extended-region access bit and signals a ROM pointer rewind when cleared.

All host accesses are single-cycle strobes; read data appears on `bus_rdata` in the cycle after the read strobe and is 0x00 otherwise. This is a register port, not a data stream, so it carries no valid/ready handshake. Drive signalling and any DMA engine are outside the block.

Top module: `ide_irq_gate`

## Requirements
- R1: After reset both channel enables are cleared, so `host_irq` is 0 even with both raw lines high; `ext_en`, `rom_rewind`, `bus_rdata`, `tf_cs`, `ctl_cs` are 0.
- R2: A write of any value to 0x2200 (channel 0) or 0x3200 (channel 1) sets that channel's enable. A read of the same offset clears it and returns 0x00.
- R3: A read of 0x2290 (channel 0) or 0x3290 (channel 1) returns the channel's raw interrupt level in bit 0 with bits 7..1 zero, and leaves the enables unchanged.
- R4: `host_irq` is high in the same cycle whenever some channel has its raw line high and its enable set, and low otherwise.
- R5: Writing one channel's enable offset and then reading the other channel's enable offset leaves only the first channel able to raise `host_irq`.
- R6: Reads at 0x2280, 0x2284, 0x2288 and 0x228C return type bits 0, 1, 2 and 3 in bit 0; for the type value 3 these are 1, 1, 0, 0.
- R7: An access strobe at base + (n << 6), with base 0x2000 (channel 0) or 0x3000 (channel 1) and n in 0..7, drives `tf_cs` bit 0 or bit 1 and `drv_reg` = n in that cycle. A read returns `drv_rdata` in the next cycle, and an address with nonzero bits 5..0 selects nothing.
- R8: An access strobe at 0x2380 or 0x3380 drives `ctl_cs` bit 0 or bit 1 with `drv_reg` = 0, and a read returns `drv_rdata` in the next cycle.
- R9: A write to 0x0000 loads `ext_en` from data bit 5. A write of 0x00 there also raises `rom_rewind` for the following cycle.
- R10: A read of any undecoded offset returns 0x00 and changes no enable.
- R11: When read and write strobes are high together, the access acts as a write only: no read side effect, and `bus_rdata` is 0x00 next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 14 | Host byte offset |
| bus_rd | input | 1 | Host read strobe, one cycle per access |
| bus_wr | input | 1 | Host write strobe, one cycle per access |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Read data, valid the cycle after `bus_rd`, else 0 |
| drv_irq | input | 2 | Raw interrupt level from each drive channel |
| host_irq | output | 1 | Combined gated interrupt |
| tf_cs | output | 2 | Taskfile window select per channel |
| ctl_cs | output | 2 | Control register select per channel |
| drv_reg | output | 3 | Register index within the taskfile window |
| drv_rd | output | 1 | Read strobe toward the drive bus |
| drv_wr | output | 1 | Write strobe toward the drive bus |
| drv_rdata | input | 8 | Read data from the drive bus |
| ext_en | output | 1 | Extended-region access enable |
| rom_rewind | output | 1 | One-cycle pulse after the select register is cleared |

## Verification
The gate is exercised with raw interrupt patterns 00, 01, 10 and 11 against each enable combination. This separates a correct per-channel AND from a design that ignores the enable or swaps channels. Enable reads, status reads, undecoded reads and simultaneous read/write strobes are interleaved with these patterns, so a read side effect landing on the wrong offset shows up as a changed interrupt output. All eight register slots of both taskfile windows are walked with distinct drive data, next to misaligned offsets. This tells a correct stride and channel split from off-by-one or aliased decoding.

// File: rtl/ide_gate_pkg.sv
package ide_gate_pkg;
  localparam int IG_NUM_CH = 2;

  typedef enum logic [2:0] {
    HIT_NONE,
    HIT_SEL,
    HIT_TF,
    HIT_CTL,
    HIT_EN,
    HIT_STAT,
    HIT_ID
  } hit_kind_e;

  typedef struct packed {
    hit_kind_e  kind;
    logic       ch;
    logic [2:0] idx;
  } hit_t;
endpackage

// File: rtl/ig_decode.sv
module ig_decode
  import ide_gate_pkg::*;
#(
  parameter int ADDR_W    = 14,
  parameter int CH0_BASE  = 'h2000,
  parameter int CH_SPAN   = 'h1000,
  parameter int STRIDE_SH = 6,
  parameter int NREG      = 8,
  parameter int EN_OFS    = 'h200,
  parameter int STAT_OFS  = 'h290,
  parameter int CTL_OFS   = 'h380,
  parameter int ID_OFS    = 'h280,
  parameter int ID_STEP   = 4,
  parameter int ID_BITS   = 4,
  parameter int SEL_OFS   = 0
) (
  input  logic [ADDR_W-1:0] addr,
  output hit_t              hit
);
  localparam int unsigned TF_SPAN  = NREG << STRIDE_SH;
  localparam int unsigned LOW_MASK = (1 << STRIDE_SH) - 1;

  always_comb begin
    int unsigned a;
    int unsigned base;
    a        = 32'(addr);
    hit.kind = HIT_NONE;
    hit.ch   = 1'b0;
    hit.idx  = 3'd0;
    if (a == SEL_OFS) hit.kind = HIT_SEL;
    for (int c = 0; c < IG_NUM_CH; c++) begin
      base = CH0_BASE + c * CH_SPAN;
      if (a >= base && a < base + TF_SPAN && (a & LOW_MASK) == 0) begin
        hit.kind = HIT_TF;
        hit.ch   = 1'(c);
        hit.idx  = 3'((a - base) >> STRIDE_SH);
      end
      if (a == base + CTL_OFS) begin
        hit.kind = HIT_CTL;
        hit.ch   = 1'(c);
      end
      if (a == base + EN_OFS) begin
        hit.kind = HIT_EN;
        hit.ch   = 1'(c);
      end
      if (a == base + STAT_OFS) begin
        hit.kind = HIT_STAT;
        hit.ch   = 1'(c);
      end
      if (c == 0) begin
        for (int k = 0; k < ID_BITS; k++) begin
          if (a == base + ID_OFS + k * ID_STEP) begin
            hit.kind = HIT_ID;
            hit.idx  = 3'(k);
          end
        end
      end
    end
  end
endmodule

// File: rtl/ig_chan_en.sv
module ig_chan_en (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic disarm,
  output logic en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en <= 1'b0;
    else if (arm)    en <= 1'b1;
    else if (disarm) en <= 1'b0;
  end

  p_arm_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> en);
  p_disarm_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (disarm && !arm) |=> !en);
  p_idle_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm && !disarm) |=> $stable(en));
endmodule

// File: rtl/ig_select.sv
module ig_select #(
  parameter int DATA_W  = 8,
  parameter int EXT_BIT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [DATA_W-1:0] wdata,
  output logic              ext_en,
  output logic              rom_rewind
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_en     <= 1'b0;
      rom_rewind <= 1'b0;
    end else begin
      rom_rewind <= wr_hit && (wdata == '0);
      if (wr_hit) ext_en <= wdata[EXT_BIT];
    end
  end

  p_rewind_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rom_rewind |-> !ext_en);
  p_rewind_needs_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> !rom_rewind);
endmodule

// File: rtl/ig_rdmux.sv
module ig_rdmux
  import ide_gate_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ID_BITS   = 4,
  parameter int CARD_TYPE = 3
) (
  input  hit_t                 hit,
  input  logic [IG_NUM_CH-1:0] drv_irq,
  input  logic [DATA_W-1:0]    drv_rdata,
  output logic [DATA_W-1:0]    rd_byte
);
  localparam logic [ID_BITS-1:0] TYPE_V = ID_BITS'(CARD_TYPE);

  always_comb begin
    rd_byte = '0;
    unique case (hit.kind)
      HIT_STAT:       rd_byte[0] = drv_irq[hit.ch];
      HIT_ID:         rd_byte[0] = TYPE_V[hit.idx[1:0]];
      HIT_TF, HIT_CTL: rd_byte   = drv_rdata;
      default:        rd_byte    = '0;
    endcase
  end
endmodule

// File: rtl/ide_irq_gate.sv
module ide_irq_gate
  import ide_gate_pkg::*;
#(
  parameter int ADDR_W    = 14,
  parameter int DATA_W    = 8,
  parameter int CARD_TYPE = 3,
  parameter int EXT_BIT   = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_rd,
  input  logic                 bus_wr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic [IG_NUM_CH-1:0] drv_irq,
  output logic                 host_irq,
  output logic [IG_NUM_CH-1:0] tf_cs,
  output logic [IG_NUM_CH-1:0] ctl_cs,
  output logic [2:0]           drv_reg,
  output logic                 drv_rd,
  output logic                 drv_wr,
  input  logic [DATA_W-1:0]    drv_rdata,
  output logic                 ext_en,
  output logic                 rom_rewind
);
  hit_t                 hit;
  logic                 eff_rd;
  logic                 any_acc;
  logic                 win_hit;
  logic [IG_NUM_CH-1:0] ch_en;
  logic [DATA_W-1:0]    rd_byte;

  assign eff_rd  = bus_rd && !bus_wr;
  assign any_acc = bus_rd || bus_wr;
  assign win_hit = (hit.kind == HIT_TF) || (hit.kind == HIT_CTL);

  ig_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .hit  (hit)
  );

  for (genvar c = 0; c < IG_NUM_CH; c++) begin : g_ch
    logic sel_me;
    assign sel_me = (hit.kind == HIT_EN) && (hit.ch == 1'(c));
    ig_chan_en u_en (
      .clk    (clk),
      .rst_n  (rst_n),
      .arm    (bus_wr && sel_me),
      .disarm (eff_rd && sel_me),
      .en     (ch_en[c])
    );
    assign tf_cs[c]  = any_acc && (hit.kind == HIT_TF)  && (hit.ch == 1'(c));
    assign ctl_cs[c] = any_acc && (hit.kind == HIT_CTL) && (hit.ch == 1'(c));
  end

  assign host_irq = |(drv_irq & ch_en);
  assign drv_reg  = (hit.kind == HIT_TF) ? hit.idx : 3'd0;
  assign drv_rd   = eff_rd && win_hit;
  assign drv_wr   = bus_wr && win_hit;

  ig_select #(.DATA_W(DATA_W), .EXT_BIT(EXT_BIT)) u_sel (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_hit     (bus_wr && (hit.kind == HIT_SEL)),
    .wdata      (bus_wdata),
    .ext_en     (ext_en),
    .rom_rewind (rom_rewind)
  );

  ig_rdmux #(.DATA_W(DATA_W), .CARD_TYPE(CARD_TYPE)) u_mux (
    .hit       (hit),
    .drv_irq   (drv_irq),
    .drv_rdata (drv_rdata),
    .rd_byte   (rd_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (eff_rd) bus_rdata <= rd_byte;
    else             bus_rdata <= '0;
  end

  p_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_en == '0) |-> !host_irq);
  p_cs_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tf_cs, ctl_cs}));
  p_undecoded_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_rd && hit.kind == HIT_NONE) |=> (bus_rdata == '0));
  p_dual_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_wr) |=> (bus_rdata == '0));
  p_enable_read_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_rd && hit.kind == HIT_EN) |=> (bus_rdata == '0));
endmodule

// File: tb/ide_irq_gate_test.sv
`timescale 1ns/1ps
module ide_irq_gate_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] bus_addr = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [1:0]  drv_irq = 2'b00;
  logic        host_irq;
  logic [1:0]  tf_cs, ctl_cs;
  logic [2:0]  drv_reg;
  logic        drv_rd, drv_wr;
  logic [7:0]  drv_rdata = '0;
  logic        ext_en, rom_rewind;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  ide_irq_gate uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .drv_irq(drv_irq), .host_irq(host_irq), .tf_cs(tf_cs), .ctl_cs(ctl_cs),
    .drv_reg(drv_reg), .drv_rd(drv_rd), .drv_wr(drv_wr),
    .drv_rdata(drv_rdata), .ext_en(ext_en), .rom_rewind(rom_rewind)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops one expected byte per read strobe seen at an edge
  always @(posedge clk) begin
    logic pend;
    pend = bus_rd;
    #1;
    if (pend) begin
      if (exp_q.size() == 0) begin
        chk("scoreboard underflow", 1, 0);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, int'(bus_rdata), int'(e));
      end
    end
  end

  task automatic do_wr(input logic [13:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [13:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic irq_chk(input logic [1:0] raw, input logic exp, input string t);
    drv_irq = raw;
    #1;
    chk(t, int'(host_irq), int'(exp));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    drv_irq = 2'b11;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 host_irq", int'(host_irq), 0);
    chk("R1 ext_en", int'(ext_en), 0);
    chk("R1 rewind", int'(rom_rewind), 0);
    chk("R1 rdata", int'(bus_rdata), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 host_irq after release", int'(host_irq), 0);
    chk("R1 cs", int'({tf_cs, ctl_cs}), 0);

    // R2/R4: arm channel 0 then channel 1
    do_wr(14'h2200, 8'h5A);
    irq_chk(2'b01, 1'b1, "R4 ch0 armed raw01");
    irq_chk(2'b10, 1'b0, "R4 ch0 armed raw10");
    do_wr(14'h3200, 8'h00);
    irq_chk(2'b10, 1'b1, "R2 ch1 armed raw10");
    irq_chk(2'b00, 1'b0, "R4 raw00");
    irq_chk(2'b11, 1'b1, "R4 raw11");

    // R3 status reads
    drv_irq = 2'b01;
    do_rd(14'h2290, 8'h01, "R3 stat ch0 high");
    do_rd(14'h3290, 8'h00, "R3 stat ch1 low");
    drv_irq = 2'b10;
    do_rd(14'h3290, 8'h01, "R3 stat ch1 high");
    do_rd(14'h2290, 8'h00, "R3 stat ch0 low");
    irq_chk(2'b01, 1'b1, "R3 status read kept ch0 enable");
    irq_chk(2'b10, 1'b1, "R3 status read kept ch1 enable");

    // R2 read of enable disarms
    do_rd(14'h2200, 8'h00, "R2 enable read data");
    irq_chk(2'b01, 1'b0, "R2 ch0 disarmed");
    irq_chk(2'b10, 1'b1, "R2 ch1 untouched");

    // R5 select ch1 for service
    do_wr(14'h2200, 8'hFF);
    do_wr(14'h3200, 8'h00);
    do_rd(14'h2200, 8'h00, "R5 read other");
    irq_chk(2'b01, 1'b0, "R5 ch0 excluded");
    irq_chk(2'b10, 1'b1, "R5 ch1 selected");
    // and the reverse
    do_wr(14'h2200, 8'h01);
    do_rd(14'h3200, 8'h00, "R5 read other rev");
    irq_chk(2'b10, 1'b0, "R5 ch1 excluded");
    irq_chk(2'b01, 1'b1, "R5 ch0 selected");

    // R6 card type bits
    do_rd(14'h2280, 8'h01, "R6 type bit0");
    do_rd(14'h2284, 8'h01, "R6 type bit1");
    do_rd(14'h2288, 8'h00, "R6 type bit2");
    do_rd(14'h228C, 8'h00, "R6 type bit3");

    // R7 taskfile windows
    for (int c = 0; c < 2; c++) begin
      for (int n = 0; n < 8; n++) begin
        @(negedge clk);
        bus_addr = 14'((c == 0 ? 'h2000 : 'h3000) + (n << 6));
        drv_rdata = 8'(8'h40 + c * 16 + n);
        bus_rd = 1'b1;
        exp_q.push_back(drv_rdata); tag_q.push_back("R7 taskfile read data");
        #1;
        chk("R7 tf_cs", int'(tf_cs), (c == 0) ? 1 : 2);
        chk("R7 drv_reg", int'(drv_reg), n);
        chk("R7 drv_rd", int'(drv_rd), 1);
        @(negedge clk);
        bus_rd = 1'b0;
      end
    end
    @(negedge clk);
    bus_addr = 14'h3140; bus_wr = 1'b1;
    #1;
    chk("R7 write tf_cs", int'(tf_cs), 2);
    chk("R7 write drv_wr", int'(drv_wr), 1);
    chk("R7 write drv_reg", int'(drv_reg), 5);
    @(negedge clk);
    bus_wr = 1'b0;
    @(negedge clk);
    bus_addr = 14'h2020; bus_rd = 1'b1;
    exp_q.push_back(8'h00); tag_q.push_back("R7 misaligned read data");
    #1;
    chk("R7 misaligned no cs", int'({tf_cs, ctl_cs}), 0);
    @(negedge clk);
    bus_rd = 1'b0;

    // R8 control register
    drv_rdata = 8'hC3;
    @(negedge clk);
    bus_addr = 14'h2380; bus_rd = 1'b1;
    exp_q.push_back(8'hC3); tag_q.push_back("R8 ctl ch0 read data");
    #1;
    chk("R8 ctl_cs ch0", int'(ctl_cs), 1);
    chk("R8 drv_reg ch0", int'(drv_reg), 0);
    @(negedge clk);
    bus_addr = 14'h3380;
    drv_rdata = 8'h3C;
    exp_q.push_back(8'h3C); tag_q.push_back("R8 ctl ch1 read data");
    #1;
    chk("R8 ctl_cs ch1", int'(ctl_cs), 2);
    chk("R8 no tf_cs", int'(tf_cs), 0);
    @(negedge clk);
    bus_rd = 1'b0;

    // R9 select register
    do_wr(14'h0000, 8'h20);
    chk("R9 ext_en set", int'(ext_en), 1);
    chk("R9 no rewind", int'(rom_rewind), 0);
    do_wr(14'h0000, 8'hDF);
    chk("R9 ext_en bit5 only", int'(ext_en), 0);
    do_wr(14'h0000, 8'h20);
    do_wr(14'h0000, 8'h00);
    chk("R9 ext_en cleared", int'(ext_en), 0);
    chk("R9 rewind pulse", int'(rom_rewind), 1);
    @(negedge clk);
    chk("R9 rewind one cycle", int'(rom_rewind), 0);

    // R10 undecoded reads (ch0 enabled, ch1 disabled here)
    do_rd(14'h1234, 8'h00, "R10 undecoded");
    do_rd(14'h3280, 8'h00, "R10 ch1 id slot undecoded");
    do_rd(14'h2204, 8'h00, "R10 near enable");
    irq_chk(2'b01, 1'b1, "R10 ch0 enable kept");
    irq_chk(2'b10, 1'b0, "R10 ch1 still off");

    // R11 simultaneous strobes
    @(negedge clk);
    bus_addr = 14'h2200; bus_rd = 1'b1; bus_wr = 1'b1;
    exp_q.push_back(8'h00); tag_q.push_back("R11 dual strobe data");
    @(negedge clk);
    bus_addr = 14'h3200;
    exp_q.push_back(8'h00); tag_q.push_back("R11 dual strobe data ch1");
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
    irq_chk(2'b01, 1'b1, "R11 ch0 not disarmed");
    irq_chk(2'b10, 1'b1, "R11 ch1 armed by dual");

    repeat (3) @(negedge clk);
    chk("scoreboard drained", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule